// File: doc/BRIEF.md
# Update-Protocol Coherence Cost Model

This block tracks a single memory line that is shared by a parameterised number of writeback caches kept coherent by an update-based snooping protocol. Each cycle it may take one processor access: the index of the requesting cache and a read/write flag. From this access it works out the next state of every cache's copy and classifies the access. An access is either a hit, a read miss, a bus update or a write miss. It also reports the cycle cost of the access and keeps a running total of all costs since reset.

When a cache writes to a line that other caches also hold, the new value is sent out on the bus and every copy stays valid. Copies are never invalidated. All copies start out invalid. A copy leaves the invalid state only through a miss. The model is meant for comparing access streams: a stream is driven in, one access per cycle, and the total cost is read at the end.

Top module: `upd_coh_cost`

## Requirements
- R1: After reset every copy is Invalid (state code 0), `total_cost` is 0 and `res_valid` is 0.
- R2: A read by a cache with no copy is a read miss (kind code 1) costing 90 cycles. The requester loads Exclusive-clean (code 1) if no other cache holds the line, and Shared-clean (code 2) otherwise. On this miss, an Exclusive-clean holder drops to Shared-clean, and a Modified (code 4) holder moves to Shared-modified (code 3).
- R3: A read by a cache that holds a copy in any valid state is a hit (kind code 0) costing 1 cycle, and it changes no state.
- R4: A write by a holder while at least one other cache holds the line is a bus update (kind code 2) costing 60 cycles. The writer becomes Shared-modified, every other holder becomes Shared-clean, and no valid copy ever returns to Invalid.
- R5: Repeated writes by the same cache cost 60 cycles each for as long as another cache holds the line.
- R6: A write by the sole holder is a hit costing 1 cycle, and the writer becomes Modified.
- R7: A write by a cache with no copy is a write miss (kind code 3). If no other cache holds the line, it costs 90 cycles and the writer becomes Modified. Otherwise it costs 150 cycles, the writer becomes Shared-modified and the other holders become Shared-clean.
- R8: The result of an access appears on `res_valid`/`res_kind`/`res_cost` on the clock edge that samples it. On that same edge, `total_cost` and `line_state` take on the values that include that access.
- R9: A cycle with `acc_valid` low gives `res_valid` low and leaves `total_cost` and `line_state` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_cpu | input | $clog2(NCACHE) | Index of the requesting cache |
| acc_write | input | 1 | 1 = write, 0 = read |
| res_valid | output | 1 | Result of the previous cycle's access is valid |
| res_kind | output | 2 | 0 hit, 1 read miss, 2 update, 3 write miss |
| res_cost | output | COST_W | Cycle cost of that access |
| total_cost | output | TOTAL_W | Running sum of all access costs |
| line_state | output | 3*NCACHE | Per-cache state, cache i in bits [3i+2:3i] |

## Verification
The assertions assume that `acc_cpu` always names an existing cache whenever `acc_valid` is high. They also assume that the running total never wraps within a run. The directed tasks only use indices below the cache count. Each task starts from a fresh reset, so the sums stay a few hundred cycles at most. Inputs change only on the falling clock edge, so every access is sampled once, and cleanly.

// File: rtl/ucc_pkg.sv
package ucc_pkg;
  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_EXC = 3'd1,
    ST_SHC = 3'd2,
    ST_SHM = 3'd3,
    ST_MOD = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    K_HIT   = 2'd0,
    K_RMISS = 2'd1,
    K_UPD   = 2'd2,
    K_WMISS = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/ucc_decide.sv
module ucc_decide
  import ucc_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int COST_W = 8,
  parameter int HIT_COST = 1,
  parameter int UPD_COST = 60,
  parameter int XFER_COST = 90,
  localparam int IDX_W = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  line_st_e [NCACHE-1:0] cur_st,
  input  logic [IDX_W-1:0]      cpu,
  input  logic                  wr,
  output line_st_e [NCACHE-1:0] nxt_st,
  output acc_kind_e             kind,
  output logic [COST_W-1:0]     cost
);
  logic [NCACHE-1:0] holders;
  logic [NCACHE-1:0] sel;
  logic              self_has;
  logic              others_have;

  for (genvar g = 0; g < NCACHE; g++) begin : g_hold
    assign holders[g] = (cur_st[g] != ST_INV);
    assign sel[g]     = (IDX_W'(g) == cpu);
  end

  assign self_has    = |(holders & sel);
  assign others_have = |(holders & ~sel);

  always_comb begin
    nxt_st = cur_st;
    kind   = K_HIT;
    cost   = COST_W'(HIT_COST);
    if (!wr) begin
      if (!self_has) begin
        kind = K_RMISS;
        cost = COST_W'(XFER_COST);
        for (int i = 0; i < NCACHE; i++) begin
          if (sel[i])                 nxt_st[i] = others_have ? ST_SHC : ST_EXC;
          else if (cur_st[i] == ST_EXC) nxt_st[i] = ST_SHC;
          else if (cur_st[i] == ST_MOD) nxt_st[i] = ST_SHM;
        end
      end
    end else if (!others_have) begin
      if (!self_has) begin
        kind = K_WMISS;
        cost = COST_W'(XFER_COST);
      end
      for (int i = 0; i < NCACHE; i++)
        if (sel[i]) nxt_st[i] = ST_MOD;
    end else begin
      kind = self_has ? K_UPD : K_WMISS;
      cost = self_has ? COST_W'(UPD_COST) : COST_W'(XFER_COST + UPD_COST);
      for (int i = 0; i < NCACHE; i++) begin
        if (sel[i])          nxt_st[i] = ST_SHM;
        else if (holders[i]) nxt_st[i] = ST_SHC;
      end
    end
  end
endmodule

// File: rtl/ucc_line_regs.sv
module ucc_line_regs
  import ucc_pkg::*;
#(
  parameter int NCACHE = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  line_st_e [NCACHE-1:0] nxt_st,
  output line_st_e [NCACHE-1:0] cur_st
);
  for (genvar g = 0; g < NCACHE; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)     cur_st[g] <= ST_INV;
      else if (en) cur_st[g] <= nxt_st[g];
    end

    // R4
    keep_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_st[g] != ST_INV) |=> (cur_st[g] != ST_INV));
  end

  logic [NCACHE-1:0] valid_v;
  logic [NCACHE-1:0] owner_v;
  for (genvar g = 0; g < NCACHE; g++) begin : g_vec
    assign valid_v[g] = (cur_st[g] != ST_INV);
    assign owner_v[g] = (cur_st[g] == ST_EXC) || (cur_st[g] == ST_MOD);
  end

  // R6
  sole_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (|owner_v) |-> ($countones(valid_v) == 1));
endmodule

// File: rtl/ucc_cost_accum.sv
module ucc_cost_accum
  import ucc_pkg::*;
#(
  parameter int COST_W = 8,
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  acc_kind_e          kind_in,
  input  logic [COST_W-1:0]  cost_in,
  output logic               res_valid,
  output acc_kind_e          res_kind,
  output logic [COST_W-1:0]  res_cost,
  output logic [TOTAL_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_kind  <= K_HIT;
      res_cost  <= '0;
      total     <= '0;
    end else begin
      res_valid <= en;
      if (en) begin
        res_kind <= kind_in;
        res_cost <= cost_in;
        total    <= total + TOTAL_W'(cost_in);
      end
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!res_valid && $stable(total)));

  // R8
  total_step_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (total >= TOTAL_W'(res_cost)));
endmodule

// File: rtl/upd_coh_cost.sv
module upd_coh_cost
  import ucc_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int COST_W = 8,
  parameter int TOTAL_W = 32,
  parameter int HIT_COST = 1,
  parameter int UPD_COST = 60,
  parameter int XFER_COST = 90,
  localparam int IDX_W = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_cpu,
  input  logic                  acc_write,
  output logic                  res_valid,
  output logic [1:0]            res_kind,
  output logic [COST_W-1:0]     res_cost,
  output logic [TOTAL_W-1:0]    total_cost,
  output logic [3*NCACHE-1:0]   line_state
);
  line_st_e [NCACHE-1:0] cur_st;
  line_st_e [NCACHE-1:0] nxt_st;
  acc_kind_e             d_kind;
  acc_kind_e             r_kind;
  logic [COST_W-1:0]     d_cost;

  ucc_decide #(
    .NCACHE(NCACHE), .COST_W(COST_W), .HIT_COST(HIT_COST),
    .UPD_COST(UPD_COST), .XFER_COST(XFER_COST)
  ) u_decide (
    .cur_st(cur_st), .cpu(acc_cpu), .wr(acc_write),
    .nxt_st(nxt_st), .kind(d_kind), .cost(d_cost)
  );

  ucc_line_regs #(.NCACHE(NCACHE)) u_lines (
    .clk(clk), .rst(rst), .en(acc_valid), .nxt_st(nxt_st), .cur_st(cur_st)
  );

  ucc_cost_accum #(.COST_W(COST_W), .TOTAL_W(TOTAL_W)) u_accum (
    .clk(clk), .rst(rst), .en(acc_valid), .kind_in(d_kind), .cost_in(d_cost),
    .res_valid(res_valid), .res_kind(r_kind), .res_cost(res_cost), .total(total_cost)
  );

  assign res_kind = r_kind;

  for (genvar g = 0; g < NCACHE; g++) begin : g_out
    assign line_state[3*g +: 3] = cur_st[g];
  end

  // R4
  upd_writer_shm_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && r_kind == K_UPD) |-> (cur_st[$past(acc_cpu)] == ST_SHM));

  // R2
  rmiss_cost_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && r_kind == K_RMISS) |-> (res_cost == COST_W'(XFER_COST)));

  // R3
  read_hit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && cur_st[acc_cpu] != ST_INV) |=> $stable(cur_st));
endmodule

// File: tb/upd_coh_cost_tb.sv
module upd_coh_cost_tb;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [1:0] acc_cpu = '0;
  logic acc_write = 1'b0;
  logic res_valid;
  logic [1:0] res_kind;
  logic [7:0] res_cost;
  logic [31:0] total_cost;
  logic [3*N-1:0] line_state;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  upd_coh_cost u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_cpu(acc_cpu),
    .acc_write(acc_write), .res_valid(res_valid), .res_kind(res_kind),
    .res_cost(res_cost), .total_cost(total_cost), .line_state(line_state)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; acc_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic acc(input int cpu, input bit wr, input int ekind, input int ecost, input string tag);
    acc_valid = 1'b1; acc_cpu = 2'(cpu); acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    check({tag, " valid"}, int'(res_valid), 1);
    check({tag, " kind"}, int'(res_kind), ekind);
    check({tag, " cost"}, int'(res_cost), ecost);
  endtask

  function automatic int st(input int c);
    return int'(line_state[3*c +: 3]);
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 total", int'(total_cost), 0);
    check("R1 valid", int'(res_valid), 0);
    for (int c = 0; c < N; c++) check("R1 state", st(c), 0);
  endtask

  task automatic t_stream_a();
    do_reset();
    acc(0,0,1,90,"R2 a0"); check("R2 excl", st(0), 1);
    acc(0,1,0,1,"R6 a1");  check("R6 mod", st(0), 4);
    acc(0,0,0,1,"R3 a2");  acc(0,1,0,1,"R6 a3");
    acc(1,0,1,90,"R2 a4"); check("R2 m->sm", st(0), 3); check("R2 shc", st(1), 2);
    acc(1,1,2,60,"R4 a5"); check("R4 wr sm", st(1), 3); check("R4 oth sc", st(0), 2);
    acc(1,0,0,1,"R3 a6");  acc(1,1,2,60,"R5 a7");
    acc(2,0,1,90,"R2 a8"); acc(2,1,2,60,"R4 a9");
    acc(2,0,0,1,"R3 a10"); acc(2,1,2,60,"R5 a11");
    check("R8 total stream A", int'(total_cost), 515);
  endtask

  task automatic t_stream_b();
    do_reset();
    acc(0,0,1,90,"R2 b0"); acc(1,0,1,90,"R2 b1"); acc(2,0,1,90,"R2 b2");
    acc(0,1,2,60,"R4 b3"); acc(1,1,2,60,"R4 b4"); acc(2,1,2,60,"R4 b5");
    acc(0,0,0,1,"R3 b6");  acc(1,0,0,1,"R3 b7");  acc(2,0,0,1,"R3 b8");
    acc(2,1,2,60,"R5 b9"); acc(0,1,2,60,"R4 b10");
    for (int c = 0; c < 3; c++) check("R4 no inval", int'(st(c) != 0), 1);
    check("R8 total stream B", int'(total_cost), 573);
  endtask

  task automatic t_stream_c();
    do_reset();
    acc(0,0,1,90,"R2 c0"); acc(1,0,1,90,"R2 c1"); acc(2,0,1,90,"R2 c2");
    acc(2,0,0,1,"R3 c3");
    for (int k = 0; k < 4; k++) acc(0,1,2,60,"R5 c-rep");
    acc(1,1,2,60,"R4 c8"); acc(2,1,2,60,"R4 c9");
    check("R8 total stream C", int'(total_cost), 631);
  endtask

  task automatic t_write_miss();
    do_reset();
    acc(3,1,3,90,"R7 lone"); check("R7 lone mod", st(3), 4);
    acc(0,1,3,150,"R7 shared"); check("R7 wr sm", st(0), 3); check("R7 oth sc", st(3), 2);
    acc(3,0,0,1,"R3 after wm");
    check("R8 total wm", int'(total_cost), 241);
  endtask

  task automatic t_excl_read();
    do_reset();
    acc(1,0,1,90,"R2 e0"); check("R2 e excl", st(1), 1);
    acc(2,0,1,90,"R2 e1"); check("R2 e->sc", st(1), 2); check("R2 req sc", st(2), 2);
  endtask

  task automatic t_idle();
    do_reset();
    acc(1,1,3,90,"R7 idle pre");
    for (int k = 0; k < 3; k++) begin
      acc_cpu = 2'd2; acc_write = 1'b1;
      @(negedge clk);
      check("R9 no valid", int'(res_valid), 0);
      check("R9 total", int'(total_cost), 90);
      check("R9 state", st(2), 0);
      check("R9 holder", st(1), 4);
    end
  endtask

  initial begin
    t_reset();
    t_stream_a();
    t_stream_b();
    t_stream_c();
    t_write_miss();
    t_excl_read();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule